// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of an asynchronous NOR-flash-style bus and turns a stream of write cycles into internal operations. Each write reaches it as one registered event per clock (`wr_valid` with address and data). It tracks the two-cycle unlock prefix and the set-up command that follows. It also tracks the extra cycles that program, double-word program, erase and configuration writes need. When a sequence completes, the block emits a single-cycle operation pulse that carries the latched address and data.

Alongside the pulses the block keeps the current read mode (array, autoselect or CFI), an unlock-bypass flag and a 16-bit configuration register. In bypass mode, program and double-word program are accepted without the prefix. Any cycle that breaks the expected pattern drops the decoder back to idle in read-array mode. The array, the program/erase timing engine and the supplies live elsewhere. They consume the pulses.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array), bypass_on is 0, cfg_value is 0, cfg_pdown is 0 and op_valid is 0.
- R2: The unlock prefix is data AAh with the low 11 address bits equal to 555h, then data 55h at 2AAh. The set-up cycle that follows must also be at 555h. Set-up 90h sets read_mode to 1 (autoselect) and emits op_kind 0 with the set-up address and data.
- R3: Prefix, then A0h at 555h, then one write emits op_kind 1 carrying that write's address and data. op_addr2 and op_data2 are zero.
- R4: Prefix, then 40h at 555h, then two writes emit op_kind 2. op_addr/op_data come from the first write and op_addr2/op_data2 from the second. If the two addresses differ in any bit above bit 0, no operation is emitted and the abort of R6 applies.
- R5: Prefix, then 80h at 555h, then a second prefix, then a confirm cycle at any address. A confirm of 30h emits op_kind 3 (block erase). A confirm of 10h emits op_kind 4 (bank erase). Both carry the confirm address and data.
- R6: Any cycle that does not match the expected pattern, whether in address or in data, emits nothing. It returns the decoder to idle, sets read_mode to 0 and clears bypass_on.
- R7: F0h at any address from idle, or F0h at 555h after the prefix, sets read_mode to 0. 98h with low address bits 055h from idle sets read_mode to 2 (CFI).
- R8: Prefix, then 60h at 555h, then 03h emits op_kind 7. The same edge loads cfg_value with address bits 15..0 of the 03h write. cfg_pdown follows bit 10 of cfg_value.
- R9: From idle outside bypass, B0h at any address emits op_kind 5 (suspend) and 30h at any address emits op_kind 6 (resume), with no prefix.
- R10: Prefix, then 20h at 555h, sets bypass_on with read_mode 0. While bypass is on, A0h or 40h alone starts the program or double-word sequence of R3/R4, and bypass stays on afterwards. 90h followed by 00h clears bypass_on.
- R11: Every operation appears on the outputs in the clock cycle after the write that completes it, as a one-cycle op_valid pulse. A cycle without wr_valid changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write; command byte in bits 7..0 |
| op_valid | output | 1 | One-cycle operation pulse |
| op_kind | output | 3 | Operation code (see R2 to R9) |
| op_addr | output | ADDR_W | Address of the operation (first address for double word) |
| op_addr2 | output | ADDR_W | Second address of a double-word program, else zero |
| op_data | output | DATA_W | Data of the operation (first word for double word) |
| op_data2 | output | DATA_W | Second word of a double-word program, else zero |
| read_mode | output | 2 | 0 array, 1 autoselect, 2 CFI |
| bypass_on | output | 1 | Unlock-bypass mode active |
| cfg_value | output | CFG_W | Configuration register |
| cfg_pdown | output | 1 | Power-down enable bit of the configuration register |

## Verification
The abort paths deep inside long sequences are the hardest to reach. Examples are a wrong second prefix after erase set-up, a bad erase confirm, and a double-word second address that differs above bit 0. An abort leaves no pulse, so it is visible only through the read mode. The stimulus therefore first enters autoselect or bypass and then breaks the sequence, so that the fall back to read-array mode and the cleared bypass flag show the abort at the ports. The scoreboard also fails any pulse it did not expect, which catches a sequence that completes when it should have aborted.

// File: rtl/ncs_pkg.sv
package ncs_pkg;

   typedef enum logic [2:0] {
      OP_AUTOSEL   = 3'd0,
      OP_PROG      = 3'd1,
      OP_DWPROG    = 3'd2,
      OP_BLKERASE  = 3'd3,
      OP_BANKERASE = 3'd4,
      OP_SUSPEND   = 3'd5,
      OP_RESUME    = 3'd6,
      OP_CFGWR     = 3'd7
   } op_kind_e;

   typedef enum logic [1:0] {
      RM_ARRAY   = 2'd0,
      RM_AUTOSEL = 2'd1,
      RM_CFI     = 2'd2
   } rmode_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_UNL1,
      S_UNL2,
      S_PGDATA,
      S_DW_A,
      S_DW_B,
      S_ER_U0,
      S_ER_U1,
      S_ER_CF,
      S_CFG,
      S_BYX
   } seq_state_e;

   localparam logic [7:0] CMD_RESET   = 8'hF0;
   localparam logic [7:0] CMD_ASEL    = 8'h90;
   localparam logic [7:0] CMD_CFI     = 8'h98;
   localparam logic [7:0] CMD_PROG    = 8'hA0;
   localparam logic [7:0] CMD_DWORD   = 8'h40;
   localparam logic [7:0] CMD_ERSET   = 8'h80;
   localparam logic [7:0] CMD_CFGSET  = 8'h60;
   localparam logic [7:0] CMD_BYPASS  = 8'h20;
   localparam logic [7:0] CMD_C30     = 8'h30;
   localparam logic [7:0] CMD_BANK    = 8'h10;
   localparam logic [7:0] CMD_SUSP    = 8'hB0;
   localparam logic [7:0] CMD_KEY1    = 8'hAA;
   localparam logic [7:0] CMD_KEY2    = 8'h55;
   localparam logic [7:0] CMD_CFGKEY  = 8'h03;
   localparam logic [7:0] CMD_ZERO    = 8'h00;

   localparam logic [11:0] ADR_KEY1 = 12'h555;
   localparam logic [11:0] ADR_KEY2 = 12'h2AA;
   localparam logic [11:0] ADR_CFI  = 12'h055;

   typedef struct packed {
      logic reset;
      logic asel;
      logic cfi;
      logic prog;
      logic dword;
      logic erset;
      logic cfgset;
      logic bypass;
      logic c30;
      logic bank;
      logic susp;
      logic key1;
      logic key2;
      logic cfgkey;
      logic zero;
   } cmd_hit_t;

endpackage

// File: rtl/ncs_match.sv
module ncs_match
   import ncs_pkg::*;
#(
   parameter int UNLOCK_AW = 11
) (
   input  logic [UNLOCK_AW-1:0] addr_lo,
   input  logic [7:0]           cmd,
   input  logic                 cmd_ok,
   output logic                 at_key1,
   output logic                 at_key2,
   output logic                 at_cfi,
   output cmd_hit_t             hit
);

   localparam logic [UNLOCK_AW-1:0] K1 = UNLOCK_AW'(ADR_KEY1);
   localparam logic [UNLOCK_AW-1:0] K2 = UNLOCK_AW'(ADR_KEY2);
   localparam logic [UNLOCK_AW-1:0] KC = UNLOCK_AW'(ADR_CFI);

   always_comb begin
      at_key1 = (addr_lo == K1);
      at_key2 = (addr_lo == K2);
      at_cfi  = (addr_lo == KC);
   end

   always_comb begin
      hit        = '0;
      hit.reset  = cmd_ok && (cmd == CMD_RESET);
      hit.asel   = cmd_ok && (cmd == CMD_ASEL);
      hit.cfi    = cmd_ok && (cmd == CMD_CFI);
      hit.prog   = cmd_ok && (cmd == CMD_PROG);
      hit.dword  = cmd_ok && (cmd == CMD_DWORD);
      hit.erset  = cmd_ok && (cmd == CMD_ERSET);
      hit.cfgset = cmd_ok && (cmd == CMD_CFGSET);
      hit.bypass = cmd_ok && (cmd == CMD_BYPASS);
      hit.c30    = cmd_ok && (cmd == CMD_C30);
      hit.bank   = cmd_ok && (cmd == CMD_BANK);
      hit.susp   = cmd_ok && (cmd == CMD_SUSP);
      hit.key1   = cmd_ok && (cmd == CMD_KEY1);
      hit.key2   = cmd_ok && (cmd == CMD_KEY2);
      hit.cfgkey = cmd_ok && (cmd == CMD_CFGKEY);
      hit.zero   = cmd_ok && (cmd == CMD_ZERO);
   end

endmodule

// File: rtl/ncs_fsm.sv
module ncs_fsm
   import ncs_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              at_key1,
   input  logic              at_key2,
   input  logic              at_cfi,
   input  cmd_hit_t          hit,
   output logic              cfg_load,
   output logic              op_valid,
   output logic [2:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [ADDR_W-1:0] op_addr2,
   output logic [DATA_W-1:0] op_data,
   output logic [DATA_W-1:0] op_data2,
   output logic [1:0]        read_mode,
   output logic              bypass_on
);

   seq_state_e        state_q, state_d;
   rmode_e            mode_q, mode_d;
   logic              byp_q, byp_d;
   logic [ADDR_W-1:0] first_addr_q;
   logic [DATA_W-1:0] first_data_q;

   logic              emit, abort, save_first;
   op_kind_e          kind;
   logic [ADDR_W-1:0] a1, a2;
   logic [DATA_W-1:0] d1, d2;
   logic              pair_ok;

   assign pair_ok = (wr_addr[ADDR_W-1:1] == first_addr_q[ADDR_W-1:1]);

   always_comb begin
      state_d    = state_q;
      mode_d     = mode_q;
      byp_d      = byp_q;
      emit       = 1'b0;
      abort      = 1'b0;
      save_first = 1'b0;
      kind       = OP_AUTOSEL;
      a1         = wr_addr;
      d1         = wr_data;
      a2         = '0;
      d2         = '0;
      if (wr_valid) begin
         case (state_q)
            S_IDLE: begin
               if (byp_q) begin
                  if (hit.prog)       state_d = S_PGDATA;
                  else if (hit.dword) state_d = S_DW_A;
                  else if (hit.asel)  state_d = S_BYX;
                  else                abort   = 1'b1;
               end else if (hit.reset) begin
                  mode_d = RM_ARRAY;
               end else if (hit.susp) begin
                  emit = 1'b1;
                  kind = OP_SUSPEND;
               end else if (hit.c30) begin
                  emit = 1'b1;
                  kind = OP_RESUME;
               end else if (hit.key1 && at_key1) begin
                  state_d = S_UNL1;
               end else if (hit.cfi && at_cfi) begin
                  mode_d = RM_CFI;
               end else begin
                  abort = 1'b1;
               end
            end
            S_UNL1: begin
               if (hit.key2 && at_key2) state_d = S_UNL2;
               else                     abort   = 1'b1;
            end
            S_UNL2: begin
               if (!at_key1) begin
                  abort = 1'b1;
               end else if (hit.reset) begin
                  mode_d  = RM_ARRAY;
                  state_d = S_IDLE;
               end else if (hit.asel) begin
                  mode_d  = RM_AUTOSEL;
                  emit    = 1'b1;
                  kind    = OP_AUTOSEL;
                  state_d = S_IDLE;
               end else if (hit.prog) begin
                  state_d = S_PGDATA;
               end else if (hit.dword) begin
                  state_d = S_DW_A;
               end else if (hit.erset) begin
                  state_d = S_ER_U0;
               end else if (hit.cfgset) begin
                  state_d = S_CFG;
               end else if (hit.bypass) begin
                  byp_d   = 1'b1;
                  mode_d  = RM_ARRAY;
                  state_d = S_IDLE;
               end else begin
                  abort = 1'b1;
               end
            end
            S_PGDATA: begin
               emit    = 1'b1;
               kind    = OP_PROG;
               state_d = S_IDLE;
            end
            S_DW_A: begin
               save_first = 1'b1;
               state_d    = S_DW_B;
            end
            S_DW_B: begin
               if (pair_ok) begin
                  emit    = 1'b1;
                  kind    = OP_DWPROG;
                  a1      = first_addr_q;
                  d1      = first_data_q;
                  a2      = wr_addr;
                  d2      = wr_data;
                  state_d = S_IDLE;
               end else begin
                  abort = 1'b1;
               end
            end
            S_ER_U0: begin
               if (hit.key1 && at_key1) state_d = S_ER_U1;
               else                     abort   = 1'b1;
            end
            S_ER_U1: begin
               if (hit.key2 && at_key2) state_d = S_ER_CF;
               else                     abort   = 1'b1;
            end
            S_ER_CF: begin
               if (hit.c30) begin
                  emit    = 1'b1;
                  kind    = OP_BLKERASE;
                  state_d = S_IDLE;
               end else if (hit.bank) begin
                  emit    = 1'b1;
                  kind    = OP_BANKERASE;
                  state_d = S_IDLE;
               end else begin
                  abort = 1'b1;
               end
            end
            S_CFG: begin
               if (hit.cfgkey) begin
                  emit    = 1'b1;
                  kind    = OP_CFGWR;
                  state_d = S_IDLE;
               end else begin
                  abort = 1'b1;
               end
            end
            S_BYX: begin
               if (hit.zero) begin
                  byp_d   = 1'b0;
                  mode_d  = RM_ARRAY;
                  state_d = S_IDLE;
               end else begin
                  abort = 1'b1;
               end
            end
            default: abort = 1'b1;
         endcase
         if (abort) begin
            state_d = S_IDLE;
            mode_d  = RM_ARRAY;
            byp_d   = 1'b0;
            emit    = 1'b0;
         end
      end
   end

   assign cfg_load = emit && (kind == OP_CFGWR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         mode_q       <= RM_ARRAY;
         byp_q        <= 1'b0;
         first_addr_q <= '0;
         first_data_q <= '0;
         op_valid     <= 1'b0;
         op_kind      <= 3'd0;
         op_addr      <= '0;
         op_addr2     <= '0;
         op_data      <= '0;
         op_data2     <= '0;
      end else begin
         state_q  <= state_d;
         mode_q   <= mode_d;
         byp_q    <= byp_d;
         op_valid <= emit;
         if (save_first) begin
            first_addr_q <= wr_addr;
            first_data_q <= wr_data;
         end
         if (emit) begin
            op_kind  <= kind;
            op_addr  <= a1;
            op_addr2 <= a2;
            op_data  <= d1;
            op_data2 <= d2;
         end
      end
   end

   assign read_mode = mode_q;
   assign bypass_on = byp_q;

endmodule

// File: rtl/ncs_cfg.sv
module ncs_cfg #(
   parameter int CFG_W     = 16,
   parameter int PDOWN_BIT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] value_in,
   output logic [CFG_W-1:0] value_q,
   output logic             pdown
);

   always_ff @(posedge clk) begin
      if (!rst_n)    value_q <= '0;
      else if (load) value_q <= value_in;
   end

   assign pdown = value_q[PDOWN_BIT];

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import ncs_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int DATA_W       = 16,
   parameter int UNLOCK_AW    = 11,
   parameter int CFG_W        = 16,
   parameter int PDOWN_BIT    = 10,
   parameter bit CMD_HI_CHECK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              op_valid,
   output logic [2:0]        op_kind,
   output logic [ADDR_W-1:0] op_addr,
   output logic [ADDR_W-1:0] op_addr2,
   output logic [DATA_W-1:0] op_data,
   output logic [DATA_W-1:0] op_data2,
   output logic [1:0]        read_mode,
   output logic              bypass_on,
   output logic [CFG_W-1:0]  cfg_value,
   output logic              cfg_pdown
);

   localparam int CMD_W = 8;

   if (DATA_W <= CMD_W) begin : g_bad_data_w
      $error("DATA_W must exceed the command byte width");
   end
   if (UNLOCK_AW < 11 || UNLOCK_AW > ADDR_W) begin : g_bad_unlock_aw
      $error("UNLOCK_AW must lie between 11 and ADDR_W");
   end
   if (CFG_W > ADDR_W) begin : g_bad_cfg_w
      $error("CFG_W cannot exceed ADDR_W");
   end
   if (PDOWN_BIT >= CFG_W) begin : g_bad_pdown
      $error("PDOWN_BIT must index into the configuration register");
   end

   logic     cmd_ok;
   logic     at_key1, at_key2, at_cfi;
   cmd_hit_t hit;
   logic     cfg_load;

   if (CMD_HI_CHECK) begin : g_hi_strict
      assign cmd_ok = (wr_data[DATA_W-1:CMD_W] == '0);
   end else begin : g_hi_free
      assign cmd_ok = 1'b1;
   end

   ncs_match #(
      .UNLOCK_AW (UNLOCK_AW)
   ) u_match (
      .addr_lo (wr_addr[UNLOCK_AW-1:0]),
      .cmd     (wr_data[CMD_W-1:0]),
      .cmd_ok  (cmd_ok),
      .at_key1 (at_key1),
      .at_key2 (at_key2),
      .at_cfi  (at_cfi),
      .hit     (hit)
   );

   ncs_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .at_key1   (at_key1),
      .at_key2   (at_key2),
      .at_cfi    (at_cfi),
      .hit       (hit),
      .cfg_load  (cfg_load),
      .op_valid  (op_valid),
      .op_kind   (op_kind),
      .op_addr   (op_addr),
      .op_addr2  (op_addr2),
      .op_data   (op_data),
      .op_data2  (op_data2),
      .read_mode (read_mode),
      .bypass_on (bypass_on)
   );

   ncs_cfg #(
      .CFG_W     (CFG_W),
      .PDOWN_BIT (PDOWN_BIT)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .value_in (wr_addr[CFG_W-1:0]),
      .value_q  (cfg_value),
      .pdown    (cfg_pdown)
   );

endmodule

// File: rtl/ncs_chk.sv
module ncs_chk #(
   parameter int ADDR_W = 21,
   parameter int CFG_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [7:0]        wr_addr_lo,
   input logic [7:0]        wr_cmd,
   input logic              op_valid,
   input logic [2:0]        op_kind,
   input logic [ADDR_W-1:0] op_addr,
   input logic [ADDR_W-1:1] op_addr2_hi,
   input logic [1:0]        read_mode,
   input logic              bypass_on,
   input logic [CFG_W-1:0]  cfg_value
);

   // R11
   op_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> $past(wr_valid));

   // R11
   quiet_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_valid) |-> ($stable(read_mode) && $stable(bypass_on) && !op_valid));

   // R4
   dword_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 3'd2) |-> (op_addr[ADDR_W-1:1] == op_addr2_hi));

   // R8
   cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_value) |-> (op_valid && op_kind == 3'd7));

   // R8
   cfg_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 3'd7) |-> (cfg_value == op_addr[CFG_W-1:0]));

   // R7
   cfi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (read_mode == 2'd2 && $past(read_mode) != 2'd2)
         |-> $past(wr_valid && wr_cmd == 8'h98 && wr_addr_lo == 8'h55));

   // R10
   bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass_on) |-> $past(wr_valid && wr_cmd == 8'h20));

   // R10
   bypass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_on |-> (read_mode == 2'd0));

endmodule

bind nor_cmd_decoder ncs_chk #(
   .ADDR_W (ADDR_W),
   .CFG_W  (CFG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_addr_lo  (wr_addr[7:0]),
   .wr_cmd      (wr_data[7:0]),
   .op_valid    (op_valid),
   .op_kind     (op_kind),
   .op_addr     (op_addr),
   .op_addr2_hi (op_addr2[ADDR_W-1:1]),
   .read_mode   (read_mode),
   .bypass_on   (bypass_on),
   .cfg_value   (cfg_value)
);

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb;

   localparam int AW = 21;
   localparam int DW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          op_valid;
   logic [2:0]    op_kind;
   logic [AW-1:0] op_addr, op_addr2;
   logic [DW-1:0] op_data, op_data2;
   logic [1:0]    read_mode;
   logic          bypass_on;
   logic [CW-1:0] cfg_value;
   logic          cfg_pdown;

   always #2 clk = ~clk;

   nor_cmd_decoder u_dut (
      .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid),
      .wr_addr (wr_addr), .wr_data (wr_data),
      .op_valid (op_valid), .op_kind (op_kind),
      .op_addr (op_addr), .op_addr2 (op_addr2),
      .op_data (op_data), .op_data2 (op_data2),
      .read_mode (read_mode), .bypass_on (bypass_on),
      .cfg_value (cfg_value), .cfg_pdown (cfg_pdown)
   );

   typedef struct {
      string         req;
      logic [2:0]    kind;
      logic [AW-1:0] a1;
      logic [AW-1:0] a2;
      logic [DW-1:0] d1;
      logic [DW-1:0] d2;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic expect_op(string req, logic [2:0] k, logic [AW-1:0] a1,
                            logic [DW-1:0] d1, logic [AW-1:0] a2, logic [DW-1:0] d2);
      exp_t e;
      e.req = req; e.kind = k; e.a1 = a1; e.a2 = a2; e.d1 = d1; e.d2 = d2;
      exp_q.push_back(e);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && op_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL unexpected op: actual kind %0d addr %h data %h expected none",
                     op_kind, op_addr, op_data);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.req, " kind"},  32'(op_kind),  32'(e.kind));
            check({e.req, " addr"},  32'(op_addr),  32'(e.a1));
            check({e.req, " data"},  32'(op_data),  32'(e.d1));
            check({e.req, " addr2"}, 32'(op_addr2), 32'(e.a2));
            check({e.req, " data2"}, 32'(op_data2), 32'(e.d2));
         end
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic unlock();
      wr(21'h555, 16'h00AA);
      wr(21'h2AA, 16'h0055);
   endtask

   task automatic enter_autosel(string req);
      unlock();
      expect_op(req, 3'd0, 21'h555, 16'h0090, '0, '0);
      wr(21'h555, 16'h0090);
      check({req, " mode autoselect"}, 32'(read_mode), 32'd1);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 read_mode", 32'(read_mode), 32'd0);
      check("R1 bypass",    32'(bypass_on), 32'd0);
      check("R1 cfg",       32'(cfg_value), 32'd0);
      check("R1 pdown",     32'(cfg_pdown), 32'd0);
      check("R1 op_valid",  32'(op_valid),  32'd0);

      // R2 autoselect entry
      enter_autosel("R2");
      // R7 F0 alone back to array
      wr(21'h1ABCD, 16'h00F0);
      check("R7 F0 alone", 32'(read_mode), 32'd0);
      // R7 CFI entry then prefixed F0
      wr(21'h100055, 16'h0098);
      check("R7 CFI entry", 32'(read_mode), 32'd2);
      unlock();
      wr(21'h555, 16'h00F0);
      check("R7 prefixed F0", 32'(read_mode), 32'd0);

      // R3 program
      unlock();
      wr(21'h555, 16'h00A0);
      expect_op("R3 program", 3'd1, 21'h12345, 16'hBEEF, '0, '0);
      wr(21'h12345, 16'hBEEF);

      // R4 double word
      unlock();
      wr(21'h555, 16'h0040);
      wr(21'h000A0, 16'h1111);
      expect_op("R4 dword", 3'd2, 21'h000A0, 16'h1111, 21'h000A1, 16'h2222);
      wr(21'h000A1, 16'h2222);
      // R4 mismatched pair aborts
      enter_autosel("R4");
      unlock();
      wr(21'h555, 16'h0040);
      wr(21'h000A0, 16'h3333);
      wr(21'h000B1, 16'h4444);
      check("R4 mismatch abort", 32'(read_mode), 32'd0);

      // R5 block and bank erase
      unlock();
      wr(21'h555, 16'h0080);
      unlock();
      expect_op("R5 block erase", 3'd3, 21'h18000, 16'h0030, '0, '0);
      wr(21'h18000, 16'h0030);
      unlock();
      wr(21'h555, 16'h0080);
      unlock();
      expect_op("R5 bank erase", 3'd4, 21'h1F0000, 16'h0010, '0, '0);
      wr(21'h1F0000, 16'h0010);

      // R6 aborts: bad address, bad data, bad second prefix, bad confirm
      enter_autosel("R6");
      wr(21'h555, 16'h00AA);
      wr(21'h2AB, 16'h0055);
      check("R6 bad prefix address", 32'(read_mode), 32'd0);
      enter_autosel("R6");
      wr(21'h555, 16'h00AA);
      wr(21'h2AA, 16'h0056);
      check("R6 bad prefix data", 32'(read_mode), 32'd0);
      enter_autosel("R6");
      unlock();
      wr(21'h555, 16'h0080);
      wr(21'h555, 16'h00AA);
      wr(21'h2AA, 16'h0077);
      check("R6 bad erase prefix", 32'(read_mode), 32'd0);
      enter_autosel("R6");
      unlock();
      wr(21'h555, 16'h0080);
      unlock();
      wr(21'h18000, 16'h0020);
      check("R6 bad erase confirm", 32'(read_mode), 32'd0);
      enter_autosel("R6");
      unlock();
      wr(21'h554, 16'h00A0);
      check("R6 bad setup address", 32'(read_mode), 32'd0);

      // R8 configuration write
      unlock();
      wr(21'h555, 16'h0060);
      expect_op("R8 cfg write", 3'd7, 21'h1F0400, 16'h0003, '0, '0);
      wr(21'h1F0400, 16'h0003);
      check("R8 cfg value", 32'(cfg_value), 32'h0400);
      check("R8 pdown set", 32'(cfg_pdown), 32'd1);
      unlock();
      wr(21'h555, 16'h0060);
      expect_op("R8 cfg write 2", 3'd7, 21'h00123, 16'h0003, '0, '0);
      wr(21'h00123, 16'h0003);
      check("R8 cfg value 2", 32'(cfg_value), 32'h0123);
      check("R8 pdown clear", 32'(cfg_pdown), 32'd0);
      unlock();
      wr(21'h555, 16'h0060);
      wr(21'h0FFFF, 16'h0004);
      check("R8 bad key keeps cfg", 32'(cfg_value), 32'h0123);

      // R9 suspend and resume
      expect_op("R9 suspend", 3'd5, 21'h00777, 16'h00B0, '0, '0);
      wr(21'h00777, 16'h00B0);
      expect_op("R9 resume", 3'd6, 21'h01234, 16'h0030, '0, '0);
      wr(21'h01234, 16'h0030);

      // R10 bypass mode
      enter_autosel("R10");
      unlock();
      wr(21'h555, 16'h0020);
      check("R10 bypass on", 32'(bypass_on), 32'd1);
      check("R10 bypass mode array", 32'(read_mode), 32'd0);
      wr(21'h00000, 16'h00A0);
      expect_op("R10 bypass program", 3'd1, 21'h055AA, 16'h0F0F, '0, '0);
      wr(21'h055AA, 16'h0F0F);
      check("R10 bypass held", 32'(bypass_on), 32'd1);
      wr(21'h00000, 16'h0040);
      wr(21'h00010, 16'hAAAA);
      expect_op("R10 bypass dword", 3'd2, 21'h00010, 16'hAAAA, 21'h00011, 16'hBBBB);
      wr(21'h00011, 16'hBBBB);
      wr(21'h00000, 16'h0090);
      wr(21'h00000, 16'h0000);
      check("R10 bypass exit", 32'(bypass_on), 32'd0);
      // R6 outside bypass a bare A0 aborts and emits nothing
      enter_autosel("R6");
      wr(21'h00000, 16'h00A0);
      wr(21'h00100, 16'h1234);
      check("R6 bare program aborts", 32'(read_mode), 32'd0);
      // R6 error in bypass clears bypass
      unlock();
      wr(21'h555, 16'h0020);
      wr(21'h00000, 16'h0077);
      check("R6 bypass cleared", 32'(bypass_on), 32'd0);

      // R11 quiet cycles produce nothing
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check("R11 no op without write", 32'(op_valid), 32'd0);
      end
      check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
      summary();
   end

endmodule